// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block collects inbound message-signalled interrupt writes and holds them as pending vector bits until a CPU picks them up. Storage is arranged as 16 frames of 8 termination registers, and each register holds 16 vector bits. A device-side write to a termination register sets the one vector bit chosen by the low four data bits.

A CPU read of a termination register returns its pending bitmap and clears it in the same access. Each frame also has a read-only summary register that shows which of its registers hold anything. Each frame drives one level interrupt line, which stays high while that frame has any pending vector.

Both ports carry 32-bit word addresses covering a 9 MB byte window, so byte offset B appears as word address B/4. A termination register for frame n, index x sits at byte offset n*0x80000 + x*0x10000. The summary register for frame n sits at byte offset 0x800000 + n*0x10000. Every other offset in the window is unmapped.

Top module: `msi_term_bank`

## Requirements
- R1: A termination register (frame n, index x) responds only at word address n*0x20000 + x*0x4000, which is byte offset n*0x80000 + x*0x10000.
- R2: A device write to a termination register sets pending bit wr_data[3:0] of that register. Data bits [31:4] have no effect.
- R3: A read accepted on one clock edge raises rd_ack for exactly the following cycle, with rd_data valid. Bits [31:16] of rd_data are always zero.
- R4: A termination-register read returns the pending bitmap in bits [15:0] and clears every bit it returned. A second read then returns zero.
- R5: The summary register of frame n is at word address 0x200000 + n*0x4000. Bit x of its [7:0] field is set when register x of frame n holds any pending bit. Reading it changes no state.
- R6: irq[n] is high exactly while the summary of frame n is nonzero.
- R7: If a device write and a CPU read hit the same register in one cycle, the written bit stays pending afterwards. The read data excludes that bit unless it was already pending.
- R8: A device write to an unmapped offset or to a summary register changes nothing. A read of an unmapped offset returns zero.
- R9: After reset all pending bits and all irq outputs are zero.
- R10: Writing a vector that is already pending leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Device message write strobe |
| wr_addr | input | 22 | Device write word address |
| wr_data | input | 32 | Device write data; bits [3:0] pick the vector |
| rd_valid | input | 1 | CPU read strobe |
| rd_addr | input | 22 | CPU read word address |
| rd_ack | output | 1 | Read data valid, one cycle after rd_valid |
| rd_data | output | 32 | Read data |
| irq | output | 16 | One level interrupt per frame |

## Verification
The hardest case to reach is a device write and a CPU read-to-clear landing on the same register in the same cycle. A read that clears a register removes the evidence of an earlier write, so the stimulus task drives both strobes on one edge. The task first preloads the register with a different vector, then issues the combined access, and then reads the register again. The expected value from the combined access holds only the preloaded bit, and the follow-up read must show the colliding bit alone. This case is also repeated with the colliding vector already pending.

// File: rtl/msi_term_bank.sv
module msi_term_bank #(
  parameter int NF = 16,
  parameter int NR = 8,
  parameter int NV = 16,
  parameter int AW = 22,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data,
  output logic [NF-1:0] irq
);
  localparam int FW = $clog2(NF);
  localparam int RW = $clog2(NR);
  localparam int VW = $clog2(NV);
  localparam int NT = NF * NR;
  localparam int OW = AW - 1 - FW - RW;
  localparam int IW = FW + RW;

  logic [NV-1:0] pend [NT];
  logic [NR-1:0] summ [NF];

  logic          wr_hit, rd_term, rd_sum;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [FW-1:0] rd_frame;

  assign wr_hit   = wr_valid && !wr_addr[AW-1] && (wr_addr[OW-1:0] == '0);
  assign wr_idx   = wr_addr[AW-2 -: IW];
  assign rd_term  = rd_valid && !rd_addr[AW-1] && (rd_addr[OW-1:0] == '0);
  assign rd_idx   = rd_addr[AW-2 -: IW];
  assign rd_sum   = rd_valid && rd_addr[AW-1] && (rd_addr[OW-1:0] == '0) &&
                    (rd_addr[AW-2:OW+FW] == '0);
  assign rd_frame = rd_addr[OW +: FW];

  genvar gf, gr;
  generate
    for (gf = 0; gf < NF; gf++) begin : g_frame
      for (gr = 0; gr < NR; gr++) begin : g_reg
        assign summ[gf][gr] = |pend[gf*NR+gr];
      end
      assign irq[gf] = |summ[gf];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) pend[i] <= '0;
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (wr_hit && wr_idx == IW'(i))
          pend[i] <= ((rd_term && rd_idx == IW'(i)) ? '0 : pend[i]) |
                     (NV'(1) << wr_data[VW-1:0]);
        else if (rd_term && rd_idx == IW'(i))
          pend[i] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack <= rd_valid;
      if (rd_term)     rd_data <= DW'(pend[rd_idx]);
      else if (rd_sum) rd_data <= DW'(summ[rd_frame]);
      else             rd_data <= '0;
    end
  end

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> rd_data[DW-1:NV] == '0);

  p_ack_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_ack);

  p_wr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> pend[$past(wr_idx)][$past(wr_data[VW-1:0])]);

  p_rd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_term && !(wr_hit && wr_idx == rd_idx)) |=> pend[$past(rd_idx)] == '0);

  p_sum_no_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sum && !wr_hit) |=> $stable(irq));

  p_irq_onehot_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> ($countones(irq & ~$past(irq)) == 0));

  p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_hit && !rd_valid) |=> $stable(irq));
endmodule

// File: tb/msi_term_bank_tb_top.sv
module msi_term_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [21:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_valid = 1'b0;
  logic [21:0] rd_addr = '0;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic [15:0] irq;

  always #4 clk = ~clk;

  msi_term_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  logic [15:0] model [128];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          cycles = 0;
  bit          done = 0;

  function automatic logic [21:0] t_addr(int n, int x);
    return 22'(n * 32'h20000 + x * 32'h4000);
  endfunction
  function automatic logic [21:0] s_addr(int n);
    return 22'(32'h200000 + n * 32'h4000);
  endfunction

  function automatic int decode_term(logic [21:0] a);
    if (!a[21] && a[13:0] == 0) return int'(a[20:14]);
    return -1;
  endfunction
  function automatic int decode_sum(logic [21:0] a);
    if (a[21] && a[13:0] == 0 && a[20:18] == 0) return int'(a[17:14]);
    return -1;
  endfunction

  function automatic logic [7:0] model_sum(int n);
    logic [7:0] s;
    for (int x = 0; x < 8; x++) s[x] = |model[n*8+x];
    return s;
  endfunction
  function automatic logic [15:0] model_irq();
    logic [15:0] q;
    for (int n = 0; n < 16; n++) q[n] = |model_sum(n);
    return q;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] read_expect(logic [21:0] a);
    int t, s;
    logic [31:0] e;
    t = decode_term(a);
    s = decode_sum(a);
    e = '0;
    if (t >= 0) begin e = {16'h0, model[t]}; model[t] = '0; end
    else if (s >= 0) e = {24'h0, model_sum(s)};
    return e;
  endfunction

  function automatic void write_model(logic [21:0] a, logic [31:0] d);
    int t;
    t = decode_term(a);
    if (t >= 0) model[t][d[3:0]] = 1'b1;
  endfunction

  task automatic dev_write(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    write_model(a, d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic cpu_read(logic [21:0] a, string req);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    exp_q.push_back(read_expect(a));
    tag_q.push_back(req);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic collide(logic [21:0] a, logic [31:0] d, string req);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    exp_q.push_back(read_expect(a));
    tag_q.push_back(req);
    write_model(a, d);
    @(negedge clk);
    rd_valid = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic check_irq(string req);
    @(negedge clk);
    check(irq == model_irq(), req, 32'(irq), 32'(model_irq()));
  endtask

  always @(negedge clk) begin
    if (rd_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected ack", rd_data, '0);
      end else begin
        logic [31:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        check(rd_data === e, r, rd_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_irq("R9 irq after reset");
    cpu_read(t_addr(0, 0), "R9 reg reset");
    cpu_read(t_addr(15, 7), "R9 reg reset");
    cpu_read(s_addr(3), "R9 summary reset");

    dev_write(t_addr(0, 7), 32'h5);
    check_irq("R6 irq set frame0");
    cpu_read(s_addr(0), "R5 summary bit7");
    cpu_read(s_addr(0), "R5 summary no side effect");
    cpu_read(t_addr(0, 7), "R1 R3 R4 readback");
    cpu_read(t_addr(0, 7), "R4 cleared");
    check_irq("R6 irq cleared");

    dev_write(t_addr(15, 0), 32'hFFFF_FFF3);
    cpu_read(t_addr(15, 0), "R2 upper data ignored");

    dev_write(t_addr(4, 2), 32'h9);
    dev_write(t_addr(4, 2), 32'h9);
    dev_write(t_addr(4, 2), 32'h1);
    cpu_read(s_addr(4), "R10 summary");
    cpu_read(t_addr(4, 2), "R10 repeated vector");

    for (int n = 0; n < 16; n++) dev_write(t_addr(n, n % 8), 32'(n));
    dev_write(t_addr(6, 3), 32'hF);
    check_irq("R6 all frames");
    for (int n = 0; n < 16; n++) cpu_read(s_addr(n), "R5 R1 summary sweep");
    for (int n = 0; n < 16; n++) begin
      for (int x = 0; x < 8; x++) cpu_read(t_addr(n, x), "R1 R4 sweep");
    end
    check_irq("R6 all cleared");

    dev_write(t_addr(9, 5), 32'h2);
    collide(t_addr(9, 5), 32'hC, "R7 read excludes new bit");
    cpu_read(t_addr(9, 5), "R7 new bit survives");
    dev_write(t_addr(9, 5), 32'hC);
    collide(t_addr(9, 5), 32'hC, "R7 already pending");
    cpu_read(t_addr(9, 5), "R7 re-set survives");

    dev_write(t_addr(2, 1) + 22'd1, 32'h1);
    dev_write(t_addr(2, 1) + 22'h1000, 32'h1);
    dev_write(s_addr(2), 32'h1);
    dev_write(22'h300000, 32'h1);
    check_irq("R8 ignored writes irq");
    cpu_read(t_addr(2, 1), "R8 target untouched");
    cpu_read(22'h300000, "R8 unmapped read");
    cpu_read(t_addr(2, 1) + 22'd4, "R8 unmapped read");
    cpu_read(s_addr(2) + 22'd1, "R8 unmapped read");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads acked", 32'(exp_q.size()), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule